// File: doc/BRIEF.md
# Authenticated Code Window Gate

This block sits beside a small core's fetch unit. It guards entry into, and exit from, a secure execution mode that is tied to one protected code window. A 32-bit window register gives the window. Software can write it whole, or shrink it with a masking operation. When the core branches to any address inside the window, the gate does not let execution start at that address. Instead it sends the program counter to the window base, stalls fetch and asks an external MAC engine to check the window.

When the engine answers, the gate compares the 128-bit result with a stored reference value. If they are equal, the core enters secure mode. If they differ, the core stays in normal mode and a sticky failure flag is raised.

While the core is in secure mode, the gate watches every fetch address. Code must announce that it is leaving by writing zero to a dedicated exit register. That write must land in a cycle before the first fetch outside the window. If the core leaves without announcing, it is halted for good until reset. If the exit was announced, the core simply returns to normal mode.

Top module: `secure_gate`

## Requirements
- R1: After reset the window register reads 0, secure mode, halt, failure flag, fetch stall, MAC request and redirect are all low. A write (cfg_we with cfg_op=0) stores cfg_wdata, and cfg_rdata shows it in the next cycle. Bits 15:0 hold the base page (the base address is that page times 256), and bits 31:16 hold the window size in bytes.
- R2: A masking operation (cfg_we with cfg_op=1) keeps bits 18:0 of the window register and clears bits 31:19.
- R3: In normal mode, a branch whose target lies in the range [base, base+size) makes pc_redirect_valid pulse for exactly one cycle, in the cycle after the branch, with pc_redirect equal to the base. A target outside that range, or any target when the size is 0, gives no redirect.
- R4: From the cycle after an entering branch until the cycle of mac_done, mac_req and fetch_stall stay high. During those cycles mac_base and mac_size carry the window that was captured at the branch.
- R5: If mac_result equals the reference value when mac_done is high, secure_mode is high and fetch_stall is low in the next cycle.
- R6: If mac_result differs from the reference, the core returns to normal mode with fetch_stall low, and auth_fail rises and stays high until reset.
- R7: In secure mode, a write of 0 to the exit register arms the exit. A later fetch outside the window then returns the core to normal mode without a halt. A zero write in the same cycle as the leaving fetch does not count as arming.
- R8: A fetch outside the window while the exit is not armed sets core_halt and clears secure_mode in the next cycle. core_halt then stays high until reset, and no further branch is redirected. A nonzero write to the exit register disarms a pending exit.
- R9: Writing or masking the window register in secure mode leaves secure_mode unchanged. Exit checks keep using the window that was captured at entry.
- R10: Exit register writes made outside secure mode have no effect on the next secure session.
- R11: Branches taken in secure mode, or while a MAC check is pending, produce no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window register access strobe |
| cfg_op | input | 1 | 0 = write, 1 = mask to bits 18:0 |
| cfg_wdata | input | 32 | Window register write data |
| cfg_rdata | output | 32 | Window register contents |
| ref_we | input | 1 | Reference MAC write strobe |
| ref_data | input | 128 | Reference MAC value |
| exit_we | input | 1 | Exit register write strobe |
| exit_wdata | input | 32 | Exit register write data |
| br_valid | input | 1 | Branch taken this cycle |
| br_target | input | 24 | Branch target address |
| pc_redirect_valid | output | 1 | Forces the program counter |
| pc_redirect | output | 24 | Forced program counter value |
| fetch_valid | input | 1 | Fetch issued this cycle |
| fetch_pc | input | 24 | Fetch address |
| mac_req | output | 1 | MAC check request (level) |
| mac_base | output | 24 | Window base for the MAC engine |
| mac_size | output | 16 | Window size for the MAC engine |
| mac_done | input | 1 | MAC result valid |
| mac_result | input | 128 | MAC computed over the window |
| fetch_stall | output | 1 | Holds fetch while the check is pending |
| secure_mode | output | 1 | Core is in secure mode |
| core_halt | output | 1 | Core halted after an unannounced exit |
| auth_fail | output | 1 | Sticky MAC mismatch flag |

## Verification
The hardest cases to reach are the ones where the window used for the exit check differs from the window register that software can see. Reaching them needs a full successful entry first, with a matching MAC answer. After that, the register is rewritten while the core is in secure mode, and fetches are placed inside the old window and inside the new one.

The exit-arming corners also need an established secure session before they can be driven. These are a zero write in the same cycle as the leaving fetch, a zero write followed by a nonzero one, and a zero write made while the core was in normal mode. The window boundaries are swept address by address around several windows: a normal one, a one-byte one, an empty one, and one at the very top of the address space. Every hit is driven through a failing MAC handshake, so that the gate goes back to normal mode before the next target is tried.

// File: rtl/sgate_pkg.sv
package sgate_pkg;
    localparam int PC_W       = 24;
    localparam int AUTH_W     = 32;
    localparam int PAGE_SHIFT = 8;
    localparam int BASE_W     = 16;
    localparam int SIZE_LSB   = 16;
    localparam int SIZE_W     = AUTH_W - SIZE_LSB;
    localparam int KEEP_BITS  = 19;
    localparam int MAC_W      = 128;
    localparam int LANE_W     = 32;
    localparam int LANES      = MAC_W / LANE_W;
    localparam int EXIT_W     = 32;

    localparam logic [AUTH_W-1:0] KEEP_MASK = AUTH_W'((64'd1 << KEEP_BITS) - 64'd1);

    typedef enum logic [1:0] {
        ST_NORMAL    = 2'd0,
        ST_AUTH_WAIT = 2'd1,
        ST_SECURE    = 2'd2,
        ST_HALTED    = 2'd3
    } gate_state_e;

    localparam logic AUTH_OP_WRITE = 1'b0;
    localparam logic AUTH_OP_MASK  = 1'b1;

    typedef struct packed {
        logic [PC_W-1:0]   base;
        logic [SIZE_W-1:0] size;
    } window_t;

    function automatic window_t decode_auth(input logic [AUTH_W-1:0] r);
        window_t w;
        w.base = PC_W'({r[BASE_W-1:0], {PAGE_SHIFT{1'b0}}});
        w.size = r[SIZE_LSB +: SIZE_W];
        return w;
    endfunction
endpackage

// File: rtl/sgate_authreg.sv
module sgate_authreg
    import sgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_op,
    input  logic [AUTH_W-1:0] cfg_wdata,
    output logic [AUTH_W-1:0] auth_q,
    output window_t           win
);
    always_ff @(posedge clk) begin
        if (rst) begin
            auth_q <= '0;
        end else if (cfg_we) begin
            if (cfg_op == AUTH_OP_MASK) auth_q <= auth_q & KEEP_MASK;
            else                        auth_q <= cfg_wdata;
        end
    end

    assign win = decode_auth(auth_q);

    assert_mask_clears_high_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_op == AUTH_OP_MASK) |=> ((auth_q & ~KEEP_MASK) == '0));
endmodule

// File: rtl/sgate_window_chk.sv
module sgate_window_chk
    import sgate_pkg::*;
(
    input  window_t         win,
    input  logic [PC_W-1:0] addr,
    output logic            hit
);
    localparam int EXT_W = PC_W + 2;
    logic [EXT_W-1:0] lo, hi, a;

    always_comb begin
        lo  = EXT_W'(win.base);
        hi  = lo + EXT_W'(win.size);
        a   = EXT_W'(addr);
        hit = (a >= lo) && (a < hi);
    end
endmodule

// File: rtl/sgate_mac_cmp.sv
module sgate_mac_cmp
    import sgate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_we,
    input  logic [MAC_W-1:0] ref_data,
    input  logic [MAC_W-1:0] mac_result,
    output logic             match
);
    logic [MAC_W-1:0] ref_q;
    logic [LANES-1:0] lane_eq;

    always_ff @(posedge clk) begin
        if (rst)         ref_q <= '0;
        else if (ref_we) ref_q <= ref_data;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_eq[i] = (ref_q[i*LANE_W +: LANE_W] == mac_result[i*LANE_W +: LANE_W]);
    end

    assign match = &lane_eq;
endmodule

// File: rtl/sgate_ctrl.sv
module sgate_ctrl
    import sgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              br_valid,
    input  logic              br_hit,
    input  window_t           live_win,
    input  logic              fetch_valid,
    input  logic              fetch_out,
    input  logic              exit_we,
    input  logic [EXIT_W-1:0] exit_wdata,
    input  logic              mac_done,
    input  logic              mac_match,
    output window_t           act_win,
    output logic              redirect_valid,
    output logic [PC_W-1:0]   redirect_pc,
    output logic              mac_req,
    output logic              fetch_stall,
    output logic              secure_mode,
    output logic              core_halt,
    output logic              auth_fail
);
    gate_state_e state;
    logic        armed;
    logic        leaving;

    assign leaving = fetch_valid && fetch_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= ST_NORMAL;
            act_win        <= '0;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            armed          <= 1'b0;
            auth_fail      <= 1'b0;
        end else begin
            redirect_valid <= 1'b0;
            unique case (state)
                ST_NORMAL: begin
                    armed <= 1'b0;
                    if (br_valid && br_hit) begin
                        state          <= ST_AUTH_WAIT;
                        act_win        <= live_win;
                        redirect_valid <= 1'b1;
                        redirect_pc    <= live_win.base;
                    end
                end
                ST_AUTH_WAIT: begin
                    if (mac_done) begin
                        if (mac_match) begin
                            state <= ST_SECURE;
                            armed <= 1'b0;
                        end else begin
                            state     <= ST_NORMAL;
                            auth_fail <= 1'b1;
                        end
                    end
                end
                ST_SECURE: begin
                    if (leaving) begin
                        state <= armed ? ST_NORMAL : ST_HALTED;
                        armed <= 1'b0;
                    end else if (exit_we) begin
                        armed <= (exit_wdata == '0);
                    end
                end
                default: ;
            endcase
        end
    end

    assign mac_req     = (state == ST_AUTH_WAIT);
    assign fetch_stall = (state == ST_AUTH_WAIT);
    assign secure_mode = (state == ST_SECURE);
    assign core_halt   = (state == ST_HALTED);

    assert_redirect_to_base_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NORMAL && br_valid && br_hit) |=>
            (redirect_valid && redirect_pc == $past(live_win.base)));

    assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
        (mac_req && !mac_done) |=> (mac_req && $stable(act_win)));

    assert_entry_needs_match_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(secure_mode) |-> $past(mac_done && mac_match));

    assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        auth_fail |=> auth_fail);

    assert_unarmed_exit_halts_R8: assert property (@(posedge clk) disable iff (rst)
        (secure_mode && leaving && !armed) |=> core_halt);

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        core_halt |=> (core_halt && !redirect_valid));

    assert_mode_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (secure_mode && !leaving) |=> secure_mode);

    assert_no_redirect_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (state != ST_NORMAL) |=> !redirect_valid);
endmodule

// File: rtl/secure_gate.sv
module secure_gate
    import sgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_op,
    input  logic [AUTH_W-1:0] cfg_wdata,
    output logic [AUTH_W-1:0] cfg_rdata,
    input  logic              ref_we,
    input  logic [MAC_W-1:0]  ref_data,
    input  logic              exit_we,
    input  logic [EXIT_W-1:0] exit_wdata,
    input  logic              br_valid,
    input  logic [PC_W-1:0]   br_target,
    output logic              pc_redirect_valid,
    output logic [PC_W-1:0]   pc_redirect,
    input  logic              fetch_valid,
    input  logic [PC_W-1:0]   fetch_pc,
    output logic              mac_req,
    output logic [PC_W-1:0]   mac_base,
    output logic [SIZE_W-1:0] mac_size,
    input  logic              mac_done,
    input  logic [MAC_W-1:0]  mac_result,
    output logic              fetch_stall,
    output logic              secure_mode,
    output logic              core_halt,
    output logic              auth_fail
);
    window_t live_win, act_win;
    logic    br_hit, fetch_in, mac_match;

    sgate_authreg u_authreg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_op(cfg_op),
        .cfg_wdata(cfg_wdata), .auth_q(cfg_rdata), .win(live_win)
    );

    sgate_window_chk u_br_chk (.win(live_win), .addr(br_target), .hit(br_hit));
    sgate_window_chk u_fetch_chk (.win(act_win), .addr(fetch_pc), .hit(fetch_in));

    sgate_mac_cmp u_cmp (
        .clk(clk), .rst(rst), .ref_we(ref_we), .ref_data(ref_data),
        .mac_result(mac_result), .match(mac_match)
    );

    sgate_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .br_valid(br_valid), .br_hit(br_hit), .live_win(live_win),
        .fetch_valid(fetch_valid), .fetch_out(!fetch_in),
        .exit_we(exit_we), .exit_wdata(exit_wdata),
        .mac_done(mac_done), .mac_match(mac_match),
        .act_win(act_win),
        .redirect_valid(pc_redirect_valid), .redirect_pc(pc_redirect),
        .mac_req(mac_req), .fetch_stall(fetch_stall),
        .secure_mode(secure_mode), .core_halt(core_halt), .auth_fail(auth_fail)
    );

    assign mac_base = act_win.base;
    assign mac_size = act_win.size;

    assert_rdata_tracks_write_R1: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_op == AUTH_OP_WRITE) |=> (cfg_rdata == $past(cfg_wdata)));
endmodule

// File: tb/secure_gate_bench.sv
`timescale 1ns/1ps
module secure_gate_bench;
    import sgate_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 0, cfg_op = 0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic ref_we = 0;
    logic [127:0] ref_data = '0;
    logic exit_we = 0;
    logic [31:0] exit_wdata = '0;
    logic br_valid = 0;
    logic [23:0] br_target = '0, pc_redirect;
    logic pc_redirect_valid;
    logic fetch_valid = 0;
    logic [23:0] fetch_pc = '0, mac_base;
    logic [15:0] mac_size;
    logic mac_req, mac_done = 0;
    logic [127:0] mac_result = '0;
    logic fetch_stall, secure_mode, core_halt, auth_fail;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    localparam logic [127:0] KEY = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;

    always #5 clk = ~clk;

    secure_gate u_secure_gate (.*);

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1; tick(); tick(); rst = 0;
    endtask

    task automatic write_auth(input logic [15:0] page, input logic [15:0] size);
        cfg_we = 1; cfg_op = 0; cfg_wdata = {size, page}; tick(); cfg_we = 0;
    endtask

    task automatic try_branch(input logic [15:0] page, input logic [15:0] size, input int t);
        int base = int'(page) * 256;
        bit exp = (size != 0) && (t >= base) && (t < base + int'(size));
        br_valid = 1; br_target = t[23:0]; tick(); br_valid = 0;
        chk("R3 redirect", pc_redirect_valid, exp);
        if (exp) begin
            chk("R3 pc", pc_redirect, base[23:0]);
            chk("R4 req", mac_req, 1);
            chk("R4 stall", fetch_stall, 1);
            chk("R4 base", mac_base, base[23:0]);
            chk("R4 size", mac_size, size);
            tick();
            chk("R3 pulse", pc_redirect_valid, 0);
            chk("R4 held", mac_req, 1);
            mac_done = 1; mac_result = ~KEY; tick(); mac_done = 0;
            chk("R6 normal", secure_mode, 0);
            chk("R6 stall", fetch_stall, 0);
            chk("R6 flag", auth_fail, 1);
        end else begin
            chk("R3 no req", mac_req, 0);
        end
    endtask

    task automatic sweep(input logic [15:0] page, input logic [15:0] size);
        int base = int'(page) * 256;
        write_auth(page, size);
        for (int t = base - 2; t <= base + int'(size) + 1; t++)
            if (t >= 0 && t < (1 << 24)) try_branch(page, size, t);
    endtask

    task automatic enter_secure(input logic [15:0] page, input logic [15:0] size);
        ref_we = 1; ref_data = KEY; tick(); ref_we = 0;
        write_auth(page, size);
        br_valid = 1; br_target = {page, 8'h00} + 24'd1; tick(); br_valid = 0;
        mac_done = 1; mac_result = KEY; tick(); mac_done = 0;
        chk("R5 secure", secure_mode, 1);
        chk("R5 stall", fetch_stall, 0);
    endtask

    task automatic fetch(input logic [23:0] a);
        fetch_valid = 1; fetch_pc = a; tick(); fetch_valid = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 rdata", cfg_rdata, 0);
        chk("R1 secure", secure_mode, 0);
        chk("R1 halt", core_halt, 0);
        chk("R1 fail", auth_fail, 0);
        chk("R1 stall", fetch_stall, 0);
        chk("R1 req", mac_req, 0);
        chk("R1 redirect", pc_redirect_valid, 0);
        cfg_we = 1; cfg_wdata = 32'hABCD_1234; tick(); cfg_we = 0;
        chk("R1 write", cfg_rdata, 32'hABCD_1234);
        cfg_we = 1; cfg_op = 1; tick(); cfg_we = 0; cfg_op = 0;
        chk("R2 mask", cfg_rdata, 32'h0005_1234);

        // R3 R4 R6 boundary sweeps
        sweep(16'h0002, 16'h0040);
        sweep(16'h0010, 16'h0100);
        sweep(16'h0000, 16'h0001);
        sweep(16'h0003, 16'h0000);
        sweep(16'hFFFF, 16'h0100);
        chk("R6 sticky", auth_fail, 1);

        // R5 R11 R9
        do_reset();
        enter_secure(16'h0002, 16'h0040);
        chk("R5 no fail", auth_fail, 0);
        br_valid = 1; br_target = 24'h000210; tick(); br_valid = 0;
        chk("R11 no redirect", pc_redirect_valid, 0);
        write_auth(16'h0040, 16'h0010);
        chk("R9 mode kept", secure_mode, 1);
        chk("R9 rdata", cfg_rdata, 32'h0010_0040);
        cfg_we = 1; cfg_op = 1; tick(); cfg_we = 0; cfg_op = 0;
        chk("R9 mask kept", secure_mode, 1);
        fetch(24'h000204);
        chk("R9 old window", secure_mode, 1);
        fetch(24'h004004);
        chk("R9 latched exit", core_halt, 1);

        // R7 clean exit
        do_reset();
        enter_secure(16'h0002, 16'h0040);
        fetch(24'h00023F);
        chk("R7 inside", secure_mode, 1);
        exit_we = 1; exit_wdata = 0; tick(); exit_we = 0;
        fetch(24'h000100);
        chk("R7 left", secure_mode, 0);
        chk("R7 no halt", core_halt, 0);
        try_branch(16'h0002, 16'h0040, 24'h000200);

        // R7 same-cycle write does not arm
        do_reset();
        enter_secure(16'h0002, 16'h0040);
        exit_we = 1; exit_wdata = 0; fetch(24'h000240); exit_we = 0;
        chk("R7 same cycle", core_halt, 1);

        // R8 unannounced exit
        do_reset();
        enter_secure(16'h0002, 16'h0040);
        fetch(24'h0001FF);
        chk("R8 halt", core_halt, 1);
        chk("R8 secure off", secure_mode, 0);
        tick(); tick();
        chk("R8 sticky", core_halt, 1);
        br_valid = 1; br_target = 24'h000200; tick(); br_valid = 0;
        chk("R8 no redirect", pc_redirect_valid, 0);

        // R8 disarm
        do_reset();
        enter_secure(16'h0002, 16'h0040);
        exit_we = 1; exit_wdata = 0; tick();
        exit_wdata = 32'h5; tick(); exit_we = 0;
        fetch(24'h000300);
        chk("R8 disarm", core_halt, 1);

        // R10 write outside secure mode
        do_reset();
        exit_we = 1; exit_wdata = 0; tick(); exit_we = 0;
        enter_secure(16'h0002, 16'h0040);
        fetch(24'h000300);
        chk("R10 ignored", core_halt, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule